// File: doc/BRIEF.md
# Operating-Mode Latch and Address Map Controller

This block fixes the operating mode of an 8-bit microcontroller when reset is released and owns two byte-wide control registers. The first holds the three mode bits, an internal-read visibility enable and a 4-bit interrupt priority selector. The second places the 256-byte internal RAM and the 64-byte register block on any 4 KiB page. Each cycle the block decodes the CPU address into one chip select, for the register block, the RAM or the bootstrap ROM, with fixed precedence between them.

Mode bits can change after reset only while the special bit is set. In the normal modes the map register takes a single write, and only during a short window after reset. The CPU bus is a plain strobe bus with no back-pressure. Every read or write strobe is served in the cycle it is presented, so the block never stalls the CPU. The ports carry no valid/ready pairs.

Top module: `modemap_ctrl`

## Requirements
- R1: While `rst` is high the mode bits (boot, special, mode-A) load from pins {b,a}: 10 gives 000, 11 gives 001, 00 gives 110, 01 gives 011. The last high-reset cycle fixes them, and later pin changes have no effect.
- R2: After reset the priority register reads {boot,special,mode-A,0,0101}, that is visibility 0 and priority 0101, and the map register reads 0x01.
- R3: A write to the priority register updates bits 7:5 (boot, special, mode-A) only if special is 1 before the write. Otherwise those bits keep their values.
- R4: Bits 4 (visibility) and 3:0 (priority) of the priority register take every write in any mode. Reads return the current value.
- R5: In the normal modes (special=0) the map register accepts a write only in bus cycles 0 to 63 after reset, counting the first clock edge with reset low as cycle 0. After one accepted write every later write is ignored.
- R6: In the special modes the map register accepts any number of writes at any time.
- R7: The register block is selected for addresses {REG,12'h000} through {REG,12'h03F}, where REG is map bits 3:0. The priority register sits at offset 0x3C and the map register at 0x3D. Other offsets read 0x00.
- R8: The RAM is selected for addresses {RAM,12'h000} through {RAM,12'h0FF}, where RAM is map bits 7:4.
- R9: The bootstrap ROM is selected for 0xBF40 through 0xBFFF only when the boot bit is 1.
- R10: On overlap the register block beats the RAM, and the RAM beats the ROM. At most one chip select is active.
- R11: When visibility is 1 and a read hits a selected region, `ext_data_oe` is 1 and `ext_data_out` carries the read data: the control register value for offsets 0x3C/0x3D, `int_rdata` otherwise. Otherwise `ext_data_oe` and `ext_data_out` are 0.
- R12: With both `bus_rd` and `bus_wr` low, no chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin_b | input | 1 | Mode pin B, sampled during reset |
| mode_pin_a | input | 1 | Mode pin A, sampled during reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| int_rdata | input | 8 | Read data from internal RAM/ROM/peripherals |
| cs_reg | output | 1 | Register block select |
| cs_ram | output | 1 | Internal RAM select |
| cs_rom | output | 1 | Bootstrap ROM select |
| ctrl_rdata | output | 8 | Read data of the two control registers |
| ext_data_out | output | 8 | Internal read data mirrored to the external bus |
| ext_data_oe | output | 1 | External bus drive enable for visibility |
| mode_boot | output | 1 | Boot ROM enable bit |
| mode_special | output | 1 | Special mode bit |
| mode_sel_a | output | 1 | Mode-A bit |
| vis_en | output | 1 | Internal-read visibility bit |
| prio_sel | output | 4 | Interrupt priority selector |

## Verification
The bench writes the map register in normal mode at cycle 63 and at cycle 64. A window that is off by one cycle accepts or rejects the wrong one of the two. It repeats the write after an accepted one, which catches a lock that only the counter sets. It tries to change the mode bits both before and after the special bit is cleared, so a design that checks the written value instead of the held bit misbehaves. The address walk probes every region edge and an overlap of RAM and registers on one page, which exposes inverted precedence and off-by-one region sizes.

// File: rtl/modemap_pkg.sv
package modemap_pkg;

  typedef struct packed {
    logic       boot;
    logic       special;
    logic       mda;
    logic       vis;
    logic [3:0] psel;
  } prio_reg_t;

  // Mode bits {boot, special, mode-A} from pins {b, a}
  function automatic logic [2:0] mode_from_pins(input logic pin_b, input logic pin_a);
    logic [2:0] m;
    unique case ({pin_b, pin_a})
      2'b10:   m = 3'b000;
      2'b11:   m = 3'b001;
      2'b00:   m = 3'b110;
      default: m = 3'b011;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mm_mode_reg.sv
module mm_mode_reg
  import modemap_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter logic [3:0] PSEL_RST = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_b,
  input  logic              pin_a,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output prio_reg_t         prio_q
);

  logic [2:0] pin_mode;

  assign pin_mode = mode_from_pins(pin_b, pin_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q.boot    <= pin_mode[2];
      prio_q.special <= pin_mode[1];
      prio_q.mda     <= pin_mode[0];
      prio_q.vis     <= 1'b0;
      prio_q.psel    <= PSEL_RST;
    end else if (wr_en) begin
      prio_q.vis  <= wdata[4];
      prio_q.psel <= wdata[3:0];
      if (prio_q.special) begin
        prio_q.boot    <= wdata[7];
        prio_q.special <= wdata[6];
        prio_q.mda     <= wdata[5];
      end
    end
  end

endmodule

// File: rtl/mm_map_reg.sv
module mm_map_reg #(
  parameter int         DATA_W      = 8,
  parameter int         LOCK_CYCLES = 64,
  parameter logic [7:0] MAP_RST     = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              special,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] map_q
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(LOCK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cyc_q;
  logic             locked_q;
  logic             wr_ok;

  assign wr_ok = wr_req && (special || !locked_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q    <= MAP_RST;
      cyc_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_ok) map_q <= wdata;
      if (cyc_q != CNT_LIM) cyc_q <= cyc_q + 1'b1;
      if ((wr_ok && !special) || (cyc_q == CNT_LAST)) locked_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mm_addr_dec.sv
module mm_addr_dec #(
  parameter int          ADDR_W       = 16,
  parameter int          REG_BLK_BITS = 6,
  parameter int          RAM_BLK_BITS = 8,
  parameter logic [15:0] ROM_LO       = 16'hBF40,
  parameter logic [15:0] ROM_HI       = 16'hBFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              access,
  input  logic [3:0]        ram_page,
  input  logic [3:0]        reg_page,
  input  logic              boot,
  output logic              cs_reg,
  output logic              cs_ram,
  output logic              cs_rom
);

  localparam int PAGE_LSB = ADDR_W - 4;

  logic hit_reg, hit_ram, hit_rom;

  assign hit_reg = (addr[ADDR_W-1:PAGE_LSB] == reg_page) &&
                   (addr[PAGE_LSB-1:REG_BLK_BITS] == '0);
  assign hit_ram = (addr[ADDR_W-1:PAGE_LSB] == ram_page) &&
                   (addr[PAGE_LSB-1:RAM_BLK_BITS] == '0);
  assign hit_rom = boot && (addr >= ADDR_W'(ROM_LO)) && (addr <= ADDR_W'(ROM_HI));

  // Fixed precedence: register block, then RAM, then ROM
  always_comb begin
    cs_reg = 1'b0;
    cs_ram = 1'b0;
    cs_rom = 1'b0;
    if (access) begin
      if (hit_reg)      cs_reg = 1'b1;
      else if (hit_ram) cs_ram = 1'b1;
      else if (hit_rom) cs_rom = 1'b1;
    end
  end

endmodule

// File: rtl/modemap_ctrl.sv
module modemap_ctrl
  import modemap_pkg::*;
#(
  parameter int         ADDR_W       = 16,
  parameter int         DATA_W       = 8,
  parameter int         LOCK_CYCLES  = 64,
  parameter int         REG_BLK_BITS = 6,
  parameter int         RAM_BLK_BITS = 8,
  parameter logic [5:0] PRIO_OFS     = 6'h3C,
  parameter logic [5:0] MAP_OFS      = 6'h3D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pin_b,
  input  logic              mode_pin_a,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              cs_reg,
  output logic              cs_ram,
  output logic              cs_rom,
  output logic [DATA_W-1:0] ctrl_rdata,
  output logic [DATA_W-1:0] ext_data_out,
  output logic              ext_data_oe,
  output logic              mode_boot,
  output logic              mode_special,
  output logic              mode_sel_a,
  output logic              vis_en,
  output logic [3:0]        prio_sel
);

  prio_reg_t         prio_q;
  logic [DATA_W-1:0] map_q;
  logic              hit_prio, hit_map;

  mm_addr_dec #(
    .ADDR_W(ADDR_W), .REG_BLK_BITS(REG_BLK_BITS), .RAM_BLK_BITS(RAM_BLK_BITS)
  ) u_dec (
    .addr(bus_addr), .access(bus_rd | bus_wr),
    .ram_page(map_q[7:4]), .reg_page(map_q[3:0]), .boot(prio_q.boot),
    .cs_reg(cs_reg), .cs_ram(cs_ram), .cs_rom(cs_rom)
  );

  assign hit_prio = cs_reg && (bus_addr[REG_BLK_BITS-1:0] == PRIO_OFS);
  assign hit_map  = cs_reg && (bus_addr[REG_BLK_BITS-1:0] == MAP_OFS);

  mm_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk(clk), .rst(rst), .pin_b(mode_pin_b), .pin_a(mode_pin_a),
    .wr_en(bus_wr && hit_prio), .wdata(bus_wdata), .prio_q(prio_q)
  );

  mm_map_reg #(.DATA_W(DATA_W), .LOCK_CYCLES(LOCK_CYCLES)) u_map (
    .clk(clk), .rst(rst), .wr_req(bus_wr && hit_map),
    .special(prio_q.special), .wdata(bus_wdata), .map_q(map_q)
  );

  always_comb begin
    ctrl_rdata = '0;
    if (hit_prio)     ctrl_rdata = prio_q;
    else if (hit_map) ctrl_rdata = map_q;
  end

  assign ext_data_oe  = prio_q.vis && bus_rd && (cs_reg || cs_ram || cs_rom);
  assign ext_data_out = !ext_data_oe ? '0 :
                        (hit_prio || hit_map) ? ctrl_rdata : int_rdata;

  assign mode_boot    = prio_q.boot;
  assign mode_special = prio_q.special;
  assign mode_sel_a   = prio_q.mda;
  assign vis_en       = prio_q.vis;
  assign prio_sel     = prio_q.psel;

endmodule

// File: rtl/modemap_chk.sv
module modemap_chk
  import modemap_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       mode_pin_b,
  input logic       mode_pin_a,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       cs_reg,
  input logic       cs_ram,
  input logic       cs_rom,
  input logic       ext_data_oe,
  input logic       vis_en,
  input logic       mode_boot,
  input logic       mode_special,
  input logic       mode_sel_a,
  input logic [7:0] map_val
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != CW'(LOCK_CYCLES)) cyc <= cyc + 1'b1;
  end

  // R1
  mode_latch_chk: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> ({mode_boot, mode_special, mode_sel_a} ==
                              mode_from_pins($past(mode_pin_b), $past(mode_pin_a))));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_special |=> $stable({mode_boot, mode_special, mode_sel_a}));

  // R5
  map_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_special && cyc == CW'(LOCK_CYCLES)) |=> $stable(map_val));

  // R9
  rom_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_boot |-> !cs_rom);

  // R10
  one_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_reg, cs_ram, cs_rom}));

  // R11
  vis_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> (vis_en && bus_rd));

  // R12
  idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd || bus_wr) |-> !(cs_reg || cs_ram || cs_rom));

endmodule

bind modemap_ctrl modemap_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .mode_pin_b(mode_pin_b), .mode_pin_a(mode_pin_a),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .cs_reg(cs_reg), .cs_ram(cs_ram),
  .cs_rom(cs_rom), .ext_data_oe(ext_data_oe), .vis_en(vis_en),
  .mode_boot(mode_boot), .mode_special(mode_special), .mode_sel_a(mode_sel_a),
  .map_val(map_q)
);

// File: tb/test_modemap_ctrl.sv
`timescale 1ns/1ps
module test_modemap_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_pin_b = 1'b1, mode_pin_a = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  int_rdata = '0;
  logic        cs_reg, cs_ram, cs_rom, ext_data_oe;
  logic [7:0]  ctrl_rdata, ext_data_out;
  logic        mode_boot, mode_special, mode_sel_a, vis_en;
  logic [3:0]  prio_sel;

  int n_chk = 0, n_fail = 0;
  logic [7:0] cur_map;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  modemap_ctrl i_modemap_ctrl (.*);

  // {map, addr, 5'b0, {reg,ram,rom}}
  localparam logic [31:0] VEC [14] = '{
    {8'h01, 16'h0000, 8'h02}, {8'h01, 16'h00FF, 8'h02}, {8'h01, 16'h0100, 8'h00},
    {8'h01, 16'h1000, 8'h04}, {8'h01, 16'h103F, 8'h04}, {8'h01, 16'h1040, 8'h00},
    {8'h01, 16'hBF3F, 8'h00}, {8'h01, 16'hBF40, 8'h01}, {8'h01, 16'hBFFF, 8'h01},
    {8'h01, 16'hC000, 8'h00}, {8'hBB, 16'hB000, 8'h04}, {8'hBB, 16'hB040, 8'h02},
    {8'hBB, 16'hB0FF, 8'h02}, {8'hBB, 16'hB100, 8'h00}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic b, input logic a);
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    mode_pin_b = b; mode_pin_a = a;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_map = 8'h01;
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] data);
    bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] addr, output logic [7:0] d);
    bus_addr = addr; bus_rd = 1'b1;
    #1 d = ctrl_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input logic [7:0] ofs);
    return {cur_map[3:0], 4'h0, ofs};
  endfunction

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1, R2: each pin combination; pins changed after release must not matter
    do_reset(1'b1, 1'b0); mode_pin_b = 1'b0; mode_pin_a = 1'b0; @(negedge clk);
    check("R1 single-chip", {mode_boot, mode_special, mode_sel_a}, 3'b000);
    rd(ctl(8'h3C), rv); check("R2 prio reset", rv, 8'h05);
    rd(ctl(8'h3D), rv); check("R2 map reset", rv, 8'h01);
    check("R2 vis/psel", {vis_en, prio_sel}, 5'h05);
    do_reset(1'b1, 1'b1); @(negedge clk);
    check("R1 expanded", {mode_boot, mode_special, mode_sel_a}, 3'b001);
    do_reset(1'b0, 1'b0); @(negedge clk);
    check("R1 bootstrap", {mode_boot, mode_special, mode_sel_a}, 3'b110);
    rd(ctl(8'h3C), rv); check("R2 prio reset boot", rv, 8'hC5);
    do_reset(1'b0, 1'b1); @(negedge clk);
    check("R1 test", {mode_boot, mode_special, mode_sel_a}, 3'b011);

    // R7-R10 address walk in bootstrap mode (special, so map is rewritable)
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][31:24] != cur_map) begin
        wr(ctl(8'h3D), VEC[i][31:24]);
        cur_map = VEC[i][31:24];
      end
      bus_addr = VEC[i][23:8]; bus_rd = 1'b1;
      #1 check($sformatf("R7 R8 R9 R10 decode %h", VEC[i][23:8]),
               {13'b0, cs_reg, cs_ram, cs_rom}, {13'b0, VEC[i][2:0]});
      bus_rd = 1'b0;
      @(negedge clk);
    end
    rd(ctl(8'h3E), rv); check("R7 unused offset", rv, 8'h00);

    // R12: no strobe, no select
    bus_addr = ctl(8'h00); #1;
    check("R12 idle", {cs_reg, cs_ram, cs_rom}, 3'b000);
    @(negedge clk);

    // R3, R4 in normal mode
    do_reset(1'b1, 1'b0);
    wr(ctl(8'h3C), 8'hFF);
    rd(ctl(8'h3C), rv); check("R3 R4 normal prio write", rv, 8'h1F);
    check("R4 vis/psel pins", {vis_en, prio_sel}, 5'h1F);

    // R5: write early, then second write ignored
    wr(ctl(8'h3D), 8'h23); cur_map = 8'h23;
    rd(ctl(8'h3D), rv); check("R5 first write", rv, 8'h23);
    wr(ctl(8'h3D), 8'h45);
    rd(ctl(8'h3D), rv); check("R5 second write ignored", rv, 8'h23);

    // R5: last cycle of the window (cycle 63)
    do_reset(1'b1, 1'b0);
    repeat (63) @(negedge clk);
    wr(ctl(8'h3D), 8'h67); cur_map = 8'h67;
    rd(ctl(8'h3D), rv); check("R5 cycle 63 accepted", rv, 8'h67);
    // R5: cycle 64 rejected
    do_reset(1'b1, 1'b0);
    repeat (64) @(negedge clk);
    wr(ctl(8'h3D), 8'h67);
    rd(ctl(8'h3D), rv); check("R5 cycle 64 rejected", rv, 8'h01);

    // R6: special mode, late and repeated writes
    do_reset(1'b0, 1'b1);
    repeat (100) @(negedge clk);
    wr(ctl(8'h3D), 8'h45); cur_map = 8'h45;
    rd(ctl(8'h3D), rv); check("R6 late write", rv, 8'h45);
    wr(ctl(8'h3D), 8'h56); cur_map = 8'h56;
    rd(ctl(8'h3D), rv); check("R6 repeat write", rv, 8'h56);

    // R3: leave special, then mode bits frozen
    wr(ctl(8'h3C), 8'h05);
    check("R3 clear special", {mode_boot, mode_special, mode_sel_a}, 3'b000);
    wr(ctl(8'h3C), 8'hE5);
    check("R3 write ignored in normal", {mode_boot, mode_special, mode_sel_a}, 3'b000);

    // R11 visibility
    do_reset(1'b0, 1'b0);
    wr(ctl(8'h3C), 8'hD5);
    bus_addr = 16'h0010; int_rdata = 8'hA5; bus_rd = 1'b1;
    #1 check("R11 ram visible", {7'b0, ext_data_oe, ext_data_out}, 16'h01A5);
    bus_addr = ctl(8'h3C);
    #0.5 check("R11 ctrl visible", {7'b0, ext_data_oe, ext_data_out}, 16'h01D5);
    bus_addr = 16'h5000;
    #0.5 check("R11 no region", {7'b0, ext_data_oe, ext_data_out}, 16'h0000);
    bus_rd = 1'b0;
    @(negedge clk);
    wr(ctl(8'h3C), 8'hC5);
    bus_addr = 16'h0010; bus_rd = 1'b1;
    #1 check("R11 vis off", {7'b0, ext_data_oe, ext_data_out}, 16'h0000);
    bus_rd = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule